// File: doc/BRIEF.md
# DRAM Power-Up Clock-Enable Delay Sequencer

This block sequences the clock-enable (CKE) pin of a DRAM device during power-up and times the required wait with a slow reference rather than the fast system clock. The reference is a 32.768 kHz level. Both of its edges are brought into the system clock domain, so each delay count lasts one 65.536 kHz period, about 15.26 µs. A 6-bit delay field therefore spans roughly 15 µs to 0.96 ms. Typical settings are 33 counts for the DDR3 500 µs pre-CKE wait and 14 counts for the LPDDR2 200 µs post-CKE idle. When the reference comes from an imprecise on-chip oscillator instead of a crystal, a setting of 61 leaves margin.

After a start pulse, the meaning of the delay depends on the memory-type select. For DDR3 the delay is a wait before CKE may rise, and the wait is paused for as long as the observed DRAM reset is still low. For LPDDR2, CKE is driven high at once and the delay measures the idle time that must pass before initialization continues. Completion gives a one-cycle done pulse and a sticky idle-done status. CKE then stays high until the block is reset.

Top module: `ddr_cke_seq`

## Requirements
- R1: While `rst_ni` is low and right after its release, `cke_o`, `done_o` and `idle_done_o` are all 0.
- R2: Every edge of `ref_clk_i`, rising and falling alike, is one delay count. A counted edge takes effect on the outputs on the third rising `clk_i` edge after it.
- R3: With `mem_lp_i`=0 (DDR3), `cke_o` stays 0 until the N-th counted edge after the start pulse. It rises together with a `done_o` pulse on the third `clk_i` edge after that reference edge. N is `delay_i`, latched when the start is accepted.
- R4: With `mem_lp_i`=0, reference edges seen while `dram_rst_ni` is 0 are not counted. Counting begins only once `dram_rst_ni` is 1.
- R5: With `mem_lp_i`=1 (LPDDR2), `cke_o` is 1 on the clock edge that accepts the start pulse. `done_o` fires after N counted reference edges, and `dram_rst_ni` has no effect in this mode.
- R6: A `delay_i` of 0 is treated as a count of 1.
- R7: `done_o` is high for exactly one `clk_i` cycle. `idle_done_o` rises with it and stays 1 until reset.
- R8: Once `cke_o` is 1 it stays 1 until reset. A start pulse while a sequence is counting, or after it completes, is ignored: no restart, no new latch of mode or delay, and no second done pulse.
- R9: Reference edges before the start pulse are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | 32.768 kHz reference level, asynchronous |
| start_i | input | 1 | Start pulse; accepted only while idle |
| mem_lp_i | input | 1 | Memory type: 0 = DDR3, 1 = LPDDR2; latched at start |
| delay_i | input | 6 | Delay in reference half-periods; latched at start |
| dram_rst_ni | input | 1 | Observed DRAM reset level, synchronous to clk_i |
| cke_o | output | 1 | DRAM clock enable |
| done_o | output | 1 | One-cycle pulse when the delay completes |
| idle_done_o | output | 1 | Sticky delay-complete status |

## Verification
Completion of the count and a new start pulse can fall in the same cycle. The bench provokes this by raising `start_i` on the very clock edge at which the last counted reference edge reaches the sequencer. The result is judged by `done_o` pulsing exactly once, `cke_o` and `idle_done_o` staying high, and no further done pulse appearing while more reference edges and start pulses follow. A start pulse during counting, with a changed mode and delay, is also applied. The completion tick must still be the originally programmed one.

// File: rtl/ddr_cke_seq_pkg.sv
package ddr_cke_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RST,
    ST_PRE,
    ST_POST,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic tick_o
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], ref_i};
  end

  // any change of the synchronized level is one tick
  assign tick_o = sh_q[DEPTH-1] ^ sh_q[DEPTH-2];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] target_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (cnt_q == target_i - 1'b1);
endmodule

// File: rtl/cke_seq_fsm.sv
module cke_seq_fsm
  import ddr_cke_seq_pkg::*;
#(
  parameter int DELAY_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mem_lp_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               dram_rst_ni,
  input  logic               tick_i,
  input  logic               hit_i,
  output logic               cnt_clr_o,
  output logic               cnt_en_o,
  output logic [DELAY_W-1:0] target_o,
  output logic               mode_lp_o,
  output logic               cke_o,
  output logic               done_o,
  output logic               idle_done_o
);
  seq_state_e         state_q;
  logic [DELAY_W-1:0] target_q;
  logic               lp_q, cke_q, done_q, stat_q;

  assign cnt_clr_o = (state_q == ST_IDLE);
  assign cnt_en_o  = tick_i && ((state_q == ST_POST) ||
                                (state_q == ST_PRE && dram_rst_ni));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      target_q <= DELAY_W'(1);
      lp_q     <= 1'b0;
      cke_q    <= 1'b0;
      done_q   <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          target_q <= (delay_i == '0) ? DELAY_W'(1) : delay_i;
          lp_q     <= mem_lp_i;
          if (mem_lp_i) begin
            cke_q   <= 1'b1;
            state_q <= ST_POST;
          end else begin
            state_q <= dram_rst_ni ? ST_PRE : ST_WAIT_RST;
          end
        end
        ST_WAIT_RST: if (dram_rst_ni) state_q <= ST_PRE;
        ST_PRE, ST_POST: if (hit_i) begin
          cke_q   <= 1'b1;
          done_q  <= 1'b1;
          stat_q  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign target_o    = target_q;
  assign mode_lp_o   = lp_q;
  assign cke_o       = cke_q;
  assign done_o      = done_q;
  assign idle_done_o = stat_q;
endmodule

// File: rtl/ddr_cke_seq.sv
module ddr_cke_seq #(
  parameter int DELAY_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               start_i,
  input  logic               mem_lp_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               dram_rst_ni,
  output logic               cke_o,
  output logic               done_o,
  output logic               idle_done_o
);
  logic               tick, hit, cnt_clr, cnt_en, mode_lp_q;
  logic [DELAY_W-1:0] target;

  ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_clk_i),
    .tick_o (tick)
  );

  tick_counter #(.W(DELAY_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .en_i     (cnt_en),
    .target_i (target),
    .hit_o    (hit)
  );

  cke_seq_fsm #(.DELAY_W(DELAY_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mem_lp_i    (mem_lp_i),
    .delay_i     (delay_i),
    .dram_rst_ni (dram_rst_ni),
    .tick_i      (tick),
    .hit_i       (hit),
    .cnt_clr_o   (cnt_clr),
    .cnt_en_o    (cnt_en),
    .target_o    (target),
    .mode_lp_o   (mode_lp_q),
    .cke_o       (cke_o),
    .done_o      (done_o),
    .idle_done_o (idle_done_o)
  );
endmodule

// File: rtl/ddr_cke_seq_chk.sv
module ddr_cke_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic dram_rst_ni,
  input logic cke_o,
  input logic done_o,
  input logic idle_done_o,
  input logic mode_lp_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!cke_o && !done_o && !idle_done_o)
        else $error("outputs set during reset");
    end
  end

  assert_cke_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_status_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idle_done_o);

  assert_status_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_done_o |=> idle_done_o);

  assert_status_needs_cke_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_done_o |-> cke_o);

  assert_ddr3_rise_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && !mode_lp_q) |-> ($past(dram_rst_ni) && done_o));

  assert_lp_rise_on_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && mode_lp_q) |-> $past(start_i));
endmodule

bind ddr_cke_seq ddr_cke_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dram_rst_ni (dram_rst_ni),
  .cke_o       (cke_o),
  .done_o      (done_o),
  .idle_done_o (idle_done_o),
  .mode_lp_q   (mode_lp_q)
);

// File: tb/ddr_cke_seq_tb.sv
module ddr_cke_seq_tb;
  localparam int GAP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       start = 1'b0;
  logic       mem_lp = 1'b0;
  logic [5:0] delay = '0;
  logic       dram_rst = 1'b0;
  logic       cke, done, idle_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ddr_cke_seq u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_clk_i   (ref_clk),
    .start_i     (start),
    .mem_lp_i    (mem_lp),
    .delay_i     (delay),
    .dram_rst_ni (dram_rst),
    .cke_o       (cke),
    .done_o      (done),
    .idle_done_o (idle_done)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_ref();
    ref_clk = ~ref_clk;
    nclk(GAP);
  endtask

  function automatic int exp_target(int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic run_trial(bit lp, int d, int idle_ticks, int rst_ticks,
                           bit mid_start, bit end_start);
    int tgt;
    int extra;
    tgt   = exp_target(d);
    extra = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    mem_lp   = lp;
    delay    = d[5:0];
    dram_rst = lp || (rst_ticks == 0);
    nclk(2);
    rst_n = 1'b1;
    nclk(2);
    chk("R1 cke after reset", cke, 0);
    chk("R1 status after reset", idle_done, 0);
    repeat (idle_ticks) tick_ref();
    chk("R9 cke before start", cke, 0);
    chk("R9 done before start", done, 0);
    start = 1'b1;
    nclk(1);
    start = 1'b0;
    chk("R5 cke right after start", cke, lp);
    if (!lp && rst_ticks > 0) begin
      repeat (rst_ticks) tick_ref();
      chk("R4 cke while dram reset low", cke, 0);
      chk("R4 status while dram reset low", idle_done, 0);
      dram_rst = 1'b1;
      nclk(2);
    end
    for (int i = 0; i < tgt - 1; i++) begin
      tick_ref();
      if (mid_start && i == 0) begin
        start  = 1'b1;
        mem_lp = ~lp;
        delay  = 6'd1;
        nclk(1);
        start  = 1'b0;
        mem_lp = lp;
        delay  = d[5:0];
      end
    end
    chk("R3 cke before last count", cke, lp);
    chk("R6 status before last count", idle_done, 0);
    ref_clk = ~ref_clk;
    nclk(2);
    chk("R2 done not before third edge", done, 0);
    if (end_start) start = 1'b1;
    nclk(1);
    chk("R3 done on completion", done, 1);
    chk("R3 cke on completion", cke, 1);
    chk("R7 status on completion", idle_done, 1);
    start = 1'b0;
    nclk(1);
    chk("R7 done one cycle only", done, 0);
    for (int k = 0; k < 3; k++) begin
      ref_clk = ~ref_clk;
      start = 1'b1;
      for (int j = 0; j < GAP; j++) begin
        nclk(1);
        start = 1'b0;
        if (done) extra++;
      end
    end
    chk("R8 no second done pulse", extra, 0);
    chk("R8 cke held high", cke, 1);
    chk("R7 status held high", idle_done, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20171128);
    nclk(3);
    // directed corners
    run_trial(1'b0, 33, 2, 3, 1'b1, 1'b1);
    run_trial(1'b1, 14, 1, 0, 1'b1, 1'b1);
    run_trial(1'b0, 0,  0, 0, 1'b0, 1'b0);
    run_trial(1'b1, 0,  3, 0, 1'b0, 1'b1);
    run_trial(1'b0, 0,  0, 2, 1'b0, 1'b1);
    run_trial(1'b0, 61, 0, 1, 1'b1, 1'b0);
    // constrained random
    for (int t = 0; t < 16; t++) begin
      run_trial(1'($urandom_range(0, 1)), $urandom_range(0, 12),
                $urandom_range(0, 3), $urandom_range(0, 3),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule